// File: doc/BRIEF.md
# Hinted Return Address Stack

This block predicts the destinations of subroutine returns for an instruction fetch unit. Each jump-and-link or jump-register instruction enters with its destination and base register indices. Whether each of those registers is a link register selects one of four stack actions: leave the stack alone, pop, push, or pop and then push. The return addresses are held in a small circular stack. When an action pops, the entry that was on top is offered as the predicted target.

The same instruction also carries the base register value and the 12-bit immediate. From these the block computes the real jump target and compares it with the prediction. If the stack had nothing to offer, or the two addresses differ, the block raises a mispredict and supplies the computed target as the refetch address. Prediction and resolution results are registered and appear on the cycle after the instruction is presented.

A separate pair of peek outputs shows the current top entry at all times without changing the stack.

Top module: `ras_predictor`

## Requirements
- R1: If neither rd nor rs1 is a link register, the stack is left unchanged, and the cycle after the instruction shows pred_valid=0 and mispredict=0.
- R2: If rs1 is a link register and rd is not, the top entry is popped, and the cycle after the instruction shows pred_valid=1 with pred_target equal to that entry.
- R3: If rd is a link register and rs1 is not, pc+4 is pushed and becomes the peeked top entry on the next cycle. No prediction is made.
- R4: If both rd and rs1 are link registers and they are different registers, the previous top entry is the prediction and pc+4 replaces it as the top entry in the same step. If both are the same register, the block only pushes pc+4 and makes no prediction.
- R5: The computed target is rs1_val plus the sign-extended 12-bit immediate, with bit 0 forced to 0.
- R6: On an action that pops, mispredict=1 with redirect_pc set to the computed target when the stack was empty or the popped entry differs from that target. Otherwise mispredict=0.
- R7: top_valid and top_addr always show the most recently pushed entry that has not been popped. Reading them never changes the stack.
- R8: Only register indices 1 and 5 count as link registers. Index 0 and every other index count as non-link.
- R9: The stack holds 8 entries. A push onto a full stack discards the oldest entry and keeps the newest 8.
- R10: A pop from an empty stack leaves pred_valid=0 and leaves the stack empty.
- R11: A synchronous reset empties the stack and clears pred_valid and mispredict.
- R12: While inst_valid is low, the stack is unchanged and the next cycle shows pred_valid=0 and mispredict=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inst_valid | input | 1 | A jump instruction is presented this cycle |
| rd_idx | input | 5 | Destination register index |
| rs1_idx | input | 5 | Base register index |
| pc | input | AW | Address of the jump instruction |
| rs1_val | input | AW | Value of the base register |
| imm | input | 12 | Signed immediate offset |
| pred_valid | output | 1 | A predicted target was taken from the stack |
| pred_target | output | AW | Predicted return target |
| mispredict | output | 1 | The computed target did not match the prediction |
| redirect_pc | output | AW | Corrected fetch address when mispredict is high |
| top_valid | output | 1 | The stack holds at least one entry |
| top_addr | output | AW | Current top entry (peek) |

## Verification
The hardest cases to reach are a pop-then-push on a full stack and a correct prediction right after wrap-around. Both need a long run of pushes followed by return instructions whose base value and immediate add up exactly to a given stack entry. The bench keeps a bounded queue model and sweeps every pair of rd and rs1 indices. It then runs random sequences in which each pop has an even chance of being given a base value computed as the model's top entry minus the sign-extended immediate, which steers both correct predictions and mispredicts through the wrapped buffer.

// File: rtl/ras_pkg.sv
package ras_pkg;

    typedef enum logic [1:0] {
        ACT_NONE    = 2'd0,
        ACT_POP     = 2'd1,
        ACT_PUSH    = 2'd2,
        ACT_POPPUSH = 2'd3
    } ras_act_e;

    function automatic logic act_pops(ras_act_e a);
        return (a == ACT_POP) || (a == ACT_POPPUSH);
    endfunction

endpackage

// File: rtl/ras_hint_decode.sv
module ras_hint_decode
    import ras_pkg::*;
#(
    parameter int          IDX_W  = 5,
    parameter logic [4:0]  LINK_A = 5'd1,
    parameter logic [4:0]  LINK_B = 5'd5
) (
    input  logic             valid,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [IDX_W-1:0] rs1_idx,
    output ras_act_e         act
);

    logic rd_link;
    logic rs1_link;
    logic same_reg;

    always_comb begin
        rd_link  = (rd_idx == IDX_W'(LINK_A)) || (rd_idx == IDX_W'(LINK_B));
        rs1_link = (rs1_idx == IDX_W'(LINK_A)) || (rs1_idx == IDX_W'(LINK_B));
        same_reg = (rd_idx == rs1_idx);
        act      = ACT_NONE;
        if (valid) begin
            unique case ({rd_link, rs1_link})
                2'b00: act = ACT_NONE;
                2'b01: act = ACT_POP;
                2'b10: act = ACT_PUSH;
                2'b11: act = same_reg ? ACT_PUSH : ACT_POPPUSH;
                default: act = ACT_NONE;
            endcase
        end
    end

endmodule

// File: rtl/ras_target_calc.sv
module ras_target_calc #(
    parameter int AW    = 32,
    parameter int IMM_W = 12
) (
    input  logic [AW-1:0]    pc,
    input  logic [AW-1:0]    base,
    input  logic [IMM_W-1:0] offset,
    output logic [AW-1:0]    link_addr,
    output logic [AW-1:0]    jump_target
);

    localparam int EXT_W = AW - IMM_W;

    logic [AW-1:0] offset_ext;
    logic [AW-1:0] raw_sum;

    always_comb begin
        offset_ext  = {{EXT_W{offset[IMM_W-1]}}, offset};
        raw_sum     = base + offset_ext;
        jump_target = {raw_sum[AW-1:1], 1'b0};
        link_addr   = pc + AW'(4);
    end

endmodule

// File: rtl/ras_stack.sv
module ras_stack
    import ras_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  ras_act_e      act,
    input  logic [AW-1:0] push_addr,
    output logic          top_valid,
    output logic [AW-1:0] top_addr
);

    // DEPTH is a power of two so the pointer wraps on its own
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][AW-1:0] mem;
        logic [PW-1:0]            ptr;
        logic [CW-1:0]            cnt;
    } stk_t;

    stk_t          stk_d, stk_q;
    logic [PW-1:0] top_idx;
    logic          empty;
    logic          full;

    always_comb begin
        top_idx   = stk_q.ptr - PW'(1);
        empty     = (stk_q.cnt == '0);
        full      = (stk_q.cnt == CW'(DEPTH));
        top_valid = !empty;
        top_addr  = stk_q.mem[top_idx];

        stk_d = stk_q;
        unique case (act)
            ACT_POP: begin
                if (!empty) begin
                    stk_d.ptr = top_idx;
                    stk_d.cnt = stk_q.cnt - CW'(1);
                end
            end
            ACT_PUSH: begin
                stk_d.mem[stk_q.ptr] = push_addr;
                stk_d.ptr            = stk_q.ptr + PW'(1);
                if (!full) stk_d.cnt = stk_q.cnt + CW'(1);
            end
            ACT_POPPUSH: begin
                if (!empty) begin
                    stk_d.mem[top_idx] = push_addr;
                end else begin
                    stk_d.mem[stk_q.ptr] = push_addr;
                    stk_d.ptr            = stk_q.ptr + PW'(1);
                    stk_d.cnt            = CW'(1);
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stk_q.mem <= '0;
            stk_q.ptr <= '0;
            stk_q.cnt <= '0;
        end else begin
            stk_q <= stk_d;
        end
    end

endmodule

// File: rtl/ras_predictor.sv
module ras_predictor
    import ras_pkg::*;
#(
    parameter int         AW     = 32,
    parameter int         DEPTH  = 8,
    parameter logic [4:0] LINK_A = 5'd1,
    parameter logic [4:0] LINK_B = 5'd5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inst_valid,
    input  logic [4:0]    rd_idx,
    input  logic [4:0]    rs1_idx,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] rs1_val,
    input  logic [11:0]   imm,
    output logic          pred_valid,
    output logic [AW-1:0] pred_target,
    output logic          mispredict,
    output logic [AW-1:0] redirect_pc,
    output logic          top_valid,
    output logic [AW-1:0] top_addr
);

    typedef struct packed {
        logic          pvalid;
        logic [AW-1:0] ptarget;
        logic          miss;
        logic [AW-1:0] redir;
    } res_t;

    ras_act_e      act;
    logic [AW-1:0] link_addr;
    logic [AW-1:0] jump_target;
    logic          stk_valid;
    logic [AW-1:0] stk_top;
    res_t          res_d, res_q;

    ras_hint_decode #(
        .IDX_W  (5),
        .LINK_A (LINK_A),
        .LINK_B (LINK_B)
    ) dec_i (
        .valid   (inst_valid),
        .rd_idx  (rd_idx),
        .rs1_idx (rs1_idx),
        .act     (act)
    );

    ras_target_calc #(
        .AW    (AW),
        .IMM_W (12)
    ) tgt_i (
        .pc          (pc),
        .base        (rs1_val),
        .offset      (imm),
        .link_addr   (link_addr),
        .jump_target (jump_target)
    );

    ras_stack #(
        .AW    (AW),
        .DEPTH (DEPTH)
    ) stk_i (
        .clk       (clk),
        .rst       (rst),
        .act       (act),
        .push_addr (link_addr),
        .top_valid (stk_valid),
        .top_addr  (stk_top)
    );

    always_comb begin
        res_d = '0;
        if (act_pops(act)) begin
            res_d.pvalid  = stk_valid;
            res_d.ptarget = stk_valid ? stk_top : '0;
            res_d.miss    = !stk_valid || (stk_top != jump_target);
            res_d.redir   = res_d.miss ? jump_target : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= res_d;
    end

    assign pred_valid  = res_q.pvalid;
    assign pred_target = res_q.ptarget;
    assign mispredict  = res_q.miss;
    assign redirect_pc = res_q.redir;
    assign top_valid   = stk_valid;
    assign top_addr    = stk_top;

endmodule

// File: rtl/ras_predictor_chk.sv
module ras_predictor_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          inst_valid,
    input logic [4:0]    rd_idx,
    input logic [4:0]    rs1_idx,
    input logic [AW-1:0] pc,
    input logic          pred_valid,
    input logic [AW-1:0] pred_target,
    input logic          mispredict,
    input logic [AW-1:0] redirect_pc,
    input logic          top_valid,
    input logic [AW-1:0] top_addr
);

    logic rd_lk, rs1_lk, rst_d1;
    assign rd_lk  = (rd_idx == 5'd1) || (rd_idx == 5'd5);
    assign rs1_lk = (rs1_idx == 5'd1) || (rs1_idx == 5'd5);

    always_ff @(posedge clk) rst_d1 <= rst;

    // R1
    no_link_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        inst_valid && !rd_lk && !rs1_lk |=> !pred_valid && !mispredict
            && $stable(top_valid) && $stable(top_addr));

    // R2
    pop_predicts_top_chk: assert property (@(posedge clk) disable iff (rst)
        inst_valid && !rd_lk && rs1_lk && top_valid |=>
            pred_valid && pred_target == $past(top_addr));

    // R3
    push_link_chk: assert property (@(posedge clk) disable iff (rst)
        inst_valid && rd_lk && !rs1_lk |=>
            top_valid && !pred_valid && top_addr == $past(pc) + AW'(4));

    // R4
    swap_chk: assert property (@(posedge clk) disable iff (rst)
        inst_valid && rd_lk && rs1_lk && rd_idx != rs1_idx && top_valid |=>
            pred_valid && pred_target == $past(top_addr)
            && top_addr == $past(pc) + AW'(4));

    // R6
    miss_differs_chk: assert property (@(posedge clk) disable iff (rst)
        pred_valid && mispredict |-> pred_target != redirect_pc);

    // R10
    empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
        inst_valid && !rd_lk && rs1_lk && !top_valid |=>
            !pred_valid && mispredict && !top_valid);

    // R12
    idle_chk: assert property (@(posedge clk) disable iff (rst)
        !inst_valid |=> !pred_valid && !mispredict
            && $stable(top_valid) && $stable(top_addr));

    // R11
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        rst_d1 |-> !top_valid && !pred_valid && !mispredict);

endmodule

bind ras_predictor ras_predictor_chk #(.AW(AW)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .inst_valid  (inst_valid),
    .rd_idx      (rd_idx),
    .rs1_idx     (rs1_idx),
    .pc          (pc),
    .pred_valid  (pred_valid),
    .pred_target (pred_target),
    .mispredict  (mispredict),
    .redirect_pc (redirect_pc),
    .top_valid   (top_valid),
    .top_addr    (top_addr)
);

// File: tb/ras_predictor_tb_top.sv
module ras_predictor_tb_top;

    localparam int AW    = 32;
    localparam int DEPTH = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          inst_valid = 1'b0;
    logic [4:0]    rd_idx = '0;
    logic [4:0]    rs1_idx = '0;
    logic [AW-1:0] pc = '0;
    logic [AW-1:0] rs1_val = '0;
    logic [11:0]   imm = '0;
    logic          pred_valid;
    logic [AW-1:0] pred_target;
    logic          mispredict;
    logic [AW-1:0] redirect_pc;
    logic          top_valid;
    logic [AW-1:0] top_addr;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [AW-1:0] model[$];
    logic          e_pv, e_miss;
    logic [AW-1:0] e_pt, e_rd;

    always #5 clk = ~clk;

    ras_predictor #(.AW(AW), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst), .inst_valid(inst_valid), .rd_idx(rd_idx),
        .rs1_idx(rs1_idx), .pc(pc), .rs1_val(rs1_val), .imm(imm),
        .pred_valid(pred_valid), .pred_target(pred_target),
        .mispredict(mispredict), .redirect_pc(redirect_pc),
        .top_valid(top_valid), .top_addr(top_addr)
    );

    task automatic chk(input bit ok, input string req, input logic [AW-1:0] act_v,
                       input logic [AW-1:0] exp_v);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act_v, exp_v);
        end
    endtask

    // R8: only indices 1 and 5 are link registers
    function automatic bit is_lk(input logic [4:0] r);
        return (r == 5'd1) || (r == 5'd5);
    endfunction

    // R5: target arithmetic
    function automatic logic [AW-1:0] tgt(input logic [AW-1:0] b, input logic [11:0] i);
        logic [AW-1:0] s;
        s = b + {{(AW-12){i[11]}}, i};
        return {s[AW-1:1], 1'b0};
    endfunction

    // model update and expectation, called at a negedge before driving
    task automatic op(input bit v, input logic [4:0] rd, input logic [4:0] rs,
                      input logic [AW-1:0] p, input logic [AW-1:0] b, input logic [11:0] i);
        bit dopop, dopush;
        logic [AW-1:0] t;
        t      = tgt(b, i);
        dopop  = v && is_lk(rs) && (!is_lk(rd) || rd != rs);
        dopush = v && is_lk(rd);
        e_pv = 0; e_miss = 0; e_pt = '0; e_rd = '0;
        if (dopop) begin
            if (model.size() == 0) begin          // R10
                e_miss = 1; e_rd = t;
            end else begin
                e_pv = 1; e_pt = model[$];
                void'(model.pop_back());
                e_miss = (e_pt != t);
                e_rd   = e_miss ? t : '0;
            end
        end
        if (dopush) begin
            model.push_back(p + 4);
            if (model.size() > DEPTH) void'(model.pop_front()); // R9
        end
        inst_valid = v; rd_idx = rd; rs1_idx = rs; pc = p; rs1_val = b; imm = i;
        @(negedge clk);
        chk(pred_valid == e_pv, "R2 pred_valid", AW'(pred_valid), AW'(e_pv));
        if (e_pv) chk(pred_target == e_pt, "R4 pred_target", pred_target, e_pt);
        chk(mispredict == e_miss, "R6 mispredict", AW'(mispredict), AW'(e_miss));
        if (e_miss) chk(redirect_pc == e_rd, "R5 redirect_pc", redirect_pc, e_rd);
        chk(top_valid == (model.size() != 0), "R7 top_valid", AW'(top_valid),
            AW'(model.size() != 0));
        if (model.size() != 0)
            chk(top_addr == model[$], "R3 top_addr", top_addr, model[$]);
    endtask

    function automatic logic [AW-1:0] rpc();
        return {$urandom(), 2'b00} >> 0;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] p;
        logic [11:0]   i;
        logic [4:0]    rs, rd;
        logic [AW-1:0] b;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11: reset state
        chk(!top_valid, "R11 top_valid", AW'(top_valid), 0);
        chk(!pred_valid && !mispredict, "R11 outputs", AW'({pred_valid, mispredict}), 0);

        // R10: pop on empty
        op(1, 5'd0, 5'd1, 32'h100, 32'h200, 12'h0);
        // R3, R9: overfill with pushes
        for (int k = 0; k < 11; k++) op(1, 5'd1, 5'd0, 32'h1000 + 32'(k * 16), '0, '0);
        // R1, R12: no-link and idle do not touch stack
        op(1, 5'd2, 5'd3, 32'h40, 32'h44, 12'h4);
        op(0, 5'd0, 5'd5, 32'h40, 32'h44, 12'h4);
        // R2, R5: correct prediction with negative immediate
        op(1, 5'd0, 5'd5, 32'h80, model[$] + 32'h10, 12'hff0);
        // R4: swap, and same register push-only
        op(1, 5'd5, 5'd1, 32'h2000, 32'h3, 12'h0);
        op(1, 5'd1, 5'd1, 32'h3000, 32'h3, 12'h0);
        // R9: drain fully then one more pop
        for (int k = 0; k < DEPTH + 1; k++) op(1, 5'd0, 5'd1, 32'h0, model.size() ? model[$] : 0, 12'h0);

        // R8: near-exhaustive sweep of every rd/rs1 pair
        for (int a = 0; a < 32; a++)
            for (int c = 0; c < 32; c++)
                op(1, 5'(a), 5'(c), 32'(((a * 32 + c) << 2) + 32'h4000), 32'h4000 + 32'(c << 2), 12'h0);

        // random call/return traffic, half the pops steered to hit
        for (int n = 0; n < 3000; n++) begin
            int sel;
            sel = $urandom_range(0, 9);
            p   = {$urandom(), 2'b00};
            i   = 12'($urandom());
            case (sel)
                0, 1, 2: begin rd = 5'd1; rs = 5'($urandom_range(6, 31)); end
                3, 4, 5: begin rd = 5'd0; rs = ($urandom_range(0, 1) != 0) ? 5'd1 : 5'd5; end
                6:       begin rd = 5'd5; rs = 5'd1; end
                7:       begin rd = 5'd1; rs = 5'd1; end
                default: begin rd = 5'($urandom_range(6, 31)); rs = 5'd0; end
            endcase
            b = $urandom();
            if (model.size() != 0 && $urandom_range(0, 1) != 0)
                b = model[$] - {{(AW-12){i[11]}}, i} + AW'($urandom_range(0, 1));
            op($urandom_range(0, 15) != 0, rd, rs, p, b, i);
        end

        // R11: reset mid-traffic empties the stack
        inst_valid = 0;
        rst = 1;
        @(negedge clk);
        rst = 0;
        model.delete();
        chk(!top_valid, "R11 reset empties", AW'(top_valid), 0);
        chk(!pred_valid && !mispredict, "R11 reset outputs", AW'({pred_valid, mispredict}), 0);
        op(1, 5'd0, 5'd1, 32'h500, 32'h500, 12'h0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule